// File: doc/BRIEF.md
# Local Interrupt Timer Unit

This block is a per-processor countdown timer. Software programs it through four 32-bit registers. An entry register holds the interrupt vector, a mask bit and a periodic/one-shot select. A divide register picks the prescaler ratio. A write-only register holds the starting count, and a read-only register shows the live count. The prescaler divides the bus clock, and each prescaled tick takes one from a 32-bit down-counter.

When the count runs out, the block raises an interrupt request that carries the programmed vector, unless the entry is masked. In periodic mode the count starts again from the programmed value. In one-shot mode it stays at zero. The request is held until the consumer pulses the acknowledge input. Deciding whether the interrupt is accepted, arbitrating priority and delivering it on a bus all happen outside the block.

Top module: `lit_timer`

## Requirements
- R1: After reset the entry register reads 0x00010000 (masked, vector 0, one-shot), the divide code reads 0, the live count reads 0 and no request is raised.
- R2: The register offsets are 0 for the entry, 1 for divide, 2 for the live count (read-only) and 3 for the start count (write-only, reads back 0). Read data is registered and appears the cycle after the offset is presented. Entry fields are vector in bits 7:0, mask in bit 16 and periodic in bit 17. The vector output changes only on an entry write.
- R3: The divide code sits in bits 2:0. Codes 0 to 6 select a ratio of 2^(code+1), so code 3 gives divide-by-16, and code 7 selects 1. A divide write restarts the prescaler phase.
- R4: Writing a nonzero start count N loads the counter and restarts the prescaler. The count expires, and an unmasked request rises, N*ratio cycles after the clock edge that took the write.
- R5: The live count can be read while the counter runs. After k cycles from the write edge it reads N - floor(k/ratio).
- R6: Writing the start count again while the counter runs abandons the old count, and the new expiry is timed from the second write.
- R7: In one-shot mode the counter stops at zero after expiry. It stays at zero and raises no further request.
- R8: In periodic mode the tick that would take the count to zero loads N again instead. The request repeats every N*ratio cycles, and the live count never reads 0 while running.
- R9: An unmasked expiry raises the request with the entry's vector. The request stays high until acknowledge. An expiry in the same cycle as an acknowledge keeps it high.
- R10: An expiry while the mask bit is set raises no request.
- R11: Writing a start count of zero stops the counter at once. It reads 0 and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the offset of the previous cycle |
| irq_ack | input | 1 | Acknowledge, clears the pending request |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 8 | Vector that goes with the request |

## Verification
The hardest state to reach from the ports is the live count part way through a long divide ratio. The bench reaches it by reading the count register a fixed number of cycles after a start-count write at divide-by-16. It then predicts the value from the write-edge cycle index. Expiries are timed the same way. The driver records the cycle of each write edge and queues the cycle and vector of each expected request. A request that arrives early, late or with the queue empty fails, which covers restart, masking, stop-on-zero and the absence of a one-shot reload.

// File: rtl/lit_pkg.sv
package lit_pkg;
  localparam int VEC_W    = 8;
  localparam int MASK_BIT = 16;
  localparam int PER_BIT  = 17;

  typedef enum logic [1:0] {
    OFS_ENTRY = 2'd0,
    OFS_DIV   = 2'd1,
    OFS_CUR   = 2'd2,
    OFS_START = 2'd3
  } ofs_e;

  typedef struct packed {
    logic             periodic;
    logic             mask;
    logic [VEC_W-1:0] vector;
  } entry_t;
endpackage

// File: rtl/lit_regs.sv
module lit_regs
  import lit_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] cur_count,
  output entry_t           entry,
  output logic [DIV_W-1:0] div_code,
  output logic [CNT_W-1:0] start_val,
  output logic             load,
  output logic             div_wr,
  output logic [CNT_W-1:0] rdata
);
  logic [CNT_W-1:0] rd_mux;
  logic             unused_wbits;

  assign load   = wr && (addr == OFS_START);
  assign div_wr = wr && (addr == OFS_DIV);

  assign unused_wbits = ^{wdata[CNT_W-1:PER_BIT+1], wdata[MASK_BIT-1:VEC_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      entry     <= '{periodic: 1'b0, mask: 1'b1, vector: '0};
      div_code  <= '0;
      start_val <= '0;
    end else begin
      if (wr && addr == OFS_ENTRY) begin
        entry.vector   <= wdata[VEC_W-1:0];
        entry.mask     <= wdata[MASK_BIT];
        entry.periodic <= wdata[PER_BIT];
      end
      if (div_wr)
        div_code <= wdata[DIV_W-1:0];
      if (load)
        start_val <= wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (ofs_e'(addr))
      OFS_ENTRY: begin
        rd_mux[VEC_W-1:0] = entry.vector;
        rd_mux[MASK_BIT]  = entry.mask;
        rd_mux[PER_BIT]   = entry.periodic;
      end
      OFS_DIV:   rd_mux[DIV_W-1:0] = div_code;
      OFS_CUR:   rd_mux = cur_count;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/lit_prescale.sv
module lit_prescale #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] code,
  output logic             tick
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0] phase;
  logic [PRE_W-1:0] last_phase;
  logic [PRE_W:0]   span;

  always_comb begin
    span = '0;
    span[0] = 1'b1;
    span = span << (code + 1'b1);
    if (&code) last_phase = '0;
    else       last_phase = PRE_W'(span - 1'b1);
  end

  assign tick = run && (phase == last_phase);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) phase <= '0;
    else if (tick)              phase <= '0;
    else                        phase <= phase + 1'b1;
  end
endmodule

// File: rtl/lit_counter.sv
module lit_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             periodic,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign expire = tick && running && (count == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      running <= 1'b0;
    end else if (load) begin
      count   <= load_val;
      running <= |load_val;
    end else if (tick && running) begin
      if (count == ONE) begin
        if (periodic && |reload_val) begin
          count <= reload_val;
        end else begin
          count   <= '0;
          running <= 1'b0;
        end
      end else begin
        count <= count - ONE;
      end
    end
  end
endmodule

// File: rtl/lit_irq.sv
module lit_irq (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic mask,
  input  logic ack,
  output logic req
);
  always_ff @(posedge clk) begin
    if (rst)                  req <= 1'b0;
    else if (expire && !mask) req <= 1'b1;
    else if (ack)             req <= 1'b0;
  end
endmodule

// File: rtl/lit_timer.sv
module lit_timer
  import lit_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             irq_ack,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec
);
  entry_t           entry;
  logic [DIV_W-1:0] div_code;
  logic [CNT_W-1:0] start_val;
  logic [CNT_W-1:0] count_w;
  logic             load_w;
  logic             div_wr;
  logic             running;
  logic             tick;
  logic             expire_w;
  logic             mask_w;

  assign mask_w  = entry.mask;
  assign irq_vec = entry.vector;

  lit_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr        (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .cur_count (count_w),
    .entry     (entry),
    .div_code  (div_code),
    .start_val (start_val),
    .load      (load_w),
    .div_wr    (div_wr),
    .rdata     (reg_rdata)
  );

  lit_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .restart (load_w | div_wr),
    .run     (running),
    .code    (div_code),
    .tick    (tick)
  );

  lit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .load       (load_w),
    .load_val   (reg_wdata),
    .reload_val (start_val),
    .periodic   (entry.periodic),
    .tick       (tick),
    .count      (count_w),
    .running    (running),
    .expire     (expire_w)
  );

  lit_irq u_irq (
    .clk    (clk),
    .rst    (rst),
    .expire (expire_w),
    .mask   (mask_w),
    .ack    (irq_ack),
    .req    (irq_req)
  );
endmodule

// File: rtl/lit_timer_chk.sv
module lit_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [CNT_W-1:0] reg_wdata,
  input logic             irq_ack,
  input logic             irq_req,
  input logic [7:0]       irq_vec,
  input logic             expire,
  input logic             mask,
  input logic [CNT_W-1:0] count,
  input logic             load
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !irq_ack) |=> irq_req); // R9
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (irq_req && irq_ack && !expire) |=> !irq_req); // R9
  AST_RISE_NEEDS_EXPIRY: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> $past(expire)); // R4
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> !$past(mask)); // R10
  AST_VEC_STABLE: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_addr == 2'd0) |=> $stable(irq_vec)); // R2
  AST_ZERO_STOPS: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd3 && reg_wdata == '0) |=> (count == '0)); // R11
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !load) |=> (count == '0)); // R7
endmodule

bind lit_timer lit_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .irq_ack   (irq_ack),
  .irq_req   (irq_req),
  .irq_vec   (irq_vec),
  .expire    (expire_w),
  .mask      (mask_w),
  .count     (count_w),
  .load      (load_w)
);

// File: tb/sim_lit_timer.sv
module sim_lit_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_req;
  logic [7:0]  irq_vec;
  logic        mon_ack = 1'b0;
  logic        drv_ack = 1'b0;
  logic        irq_ack;
  logic        auto_ack = 1'b1;
  logic        req_prev = 1'b0;
  logic        done = 1'b0;
  int          cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;

  typedef struct {
    int         at;
    logic [7:0] vec;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  assign irq_ack = mon_ack | drv_ack;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lit_timer u0 (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_ack   (irq_ack),
    .irq_req   (irq_req),
    .irq_vec   (irq_vec)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compare each rising request with the scoreboard queue
  always @(negedge clk) begin
    if (!rst) begin
      if (irq_req && !req_prev) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10/R11 unexpected request", 32'(cyc), 32'hffffffff);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(cyc == e.at, {e.tag, " expiry cycle"}, 32'(cyc), 32'(e.at));
          chk(irq_vec == e.vec, {e.tag, " vector"}, 32'(irq_vec), 32'(e.vec));
        end
      end
      mon_ack  = auto_ack && irq_req;
      req_prev = irq_req;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d, output int w);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    w = cyc;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d, output int c);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    c = cyc;
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic expect_irq(input int at, input logic [7:0] v, input string tag);
    exp_t e;
    e.at = at; e.vec = v; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 32'(cyc), 32'd0);
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    int w, w2, c;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(irq_req == 1'b0, "R1 request idle", 32'(irq_req), 32'd0);
    rd(2'd0, d, c); chk(d == 32'h00010000, "R1 entry reset", d, 32'h00010000);
    rd(2'd1, d, c); chk(d == 32'd0, "R1 divide reset", d, 32'd0);
    rd(2'd2, d, c); chk(d == 32'd0, "R1 count reset", d, 32'd0);

    // R2 field layout and write-only start count
    wr(2'd0, 32'h0000_0021, w);
    wr(2'd1, 32'd7, w);
    rd(2'd0, d, c); chk(d == 32'h21, "R2 entry readback", d, 32'h21);
    rd(2'd1, d, c); chk(d == 32'd7, "R3 divide readback", d, 32'd7);
    wr(2'd3, 32'd10, w);
    expect_irq(w + 10, 8'h21, "R4");
    rd(2'd3, d, c); chk(d == 32'd0, "R2 start count reads zero", d, 32'd0);
    wait_to(w + 14);
    rd(2'd2, d, c); chk(d == 32'd0, "R7 one-shot stopped", d, 32'd0);
    wait_to(w + 50);
    rd(2'd2, d, c); chk(d == 32'd0, "R7 no reload", d, 32'd0);

    // R3/R5 divide-by-16 with live reads
    wr(2'd0, 32'h0000_0033, w);
    wr(2'd1, 32'd3, w);
    wr(2'd3, 32'd4, w);
    expect_irq(w + 64, 8'h33, "R3");
    rd(2'd2, d, c); chk(d == 32'(4 - (c - 1 - w) / 16), "R5 live count early", d, 32'(4 - (c - 1 - w) / 16));
    wait_to(w + 37);
    rd(2'd2, d, c); chk(d == 32'(4 - (c - 1 - w) / 16), "R5 live count mid", d, 32'(4 - (c - 1 - w) / 16));
    wait_to(w + 70);

    // R6 restart
    wr(2'd1, 32'd7, w);
    wr(2'd3, 32'd200, w);
    wait_to(w + 50);
    wr(2'd3, 32'd30, w2);
    expect_irq(w2 + 30, 8'h33, "R6");
    wait_to(w2 + 40);
    rd(2'd2, d, c); chk(d == 32'd0, "R6 count done", d, 32'd0);
    wait_to(w + 230);

    // R10 masked expiry
    wr(2'd0, 32'h0001_0055, w);
    wr(2'd3, 32'd8, w);
    wait_to(w + 30);
    chk(irq_req == 1'b0, "R10 masked no request", 32'(irq_req), 32'd0);
    rd(2'd2, d, c); chk(d == 32'd0, "R10 count expired", d, 32'd0);

    // R11 zero write stops
    wr(2'd0, 32'h0000_0056, w);
    wr(2'd3, 32'd100, w);
    wait_to(w + 10);
    wr(2'd3, 32'd0, w);
    rd(2'd2, d, c); chk(d == 32'd0, "R11 count stopped", d, 32'd0);
    wait_to(w + 150);
    chk(irq_req == 1'b0, "R11 no request", 32'(irq_req), 32'd0);

    // R8 periodic at divide-by-2
    wr(2'd0, 32'h0002_0042, w);
    wr(2'd1, 32'd0, w);
    wr(2'd3, 32'd5, w);
    expect_irq(w + 10, 8'h42, "R8");
    expect_irq(w + 20, 8'h42, "R8");
    expect_irq(w + 30, 8'h42, "R8");
    wait_to(w + 19);
    rd(2'd2, d, c);
    chk(d == 32'(5 - (((c - 1 - w) / 2) % 5)), "R8 reloaded count", d, 32'(5 - (((c - 1 - w) / 2) % 5)));
    wait_to(w + 31);
    wr(2'd3, 32'd0, w2);
    wait_to(w2 + 40);
    chk(exp_q.size() == 0, "R8 all periods seen", 32'(exp_q.size()), 32'd0);

    // R9 request held until acknowledge
    auto_ack = 1'b0;
    wr(2'd0, 32'h0000_0077, w);
    wr(2'd1, 32'd7, w);
    wr(2'd3, 32'd3, w);
    expect_irq(w + 3, 8'h77, "R9");
    wait_to(w + 20);
    chk(irq_req == 1'b1, "R9 request held", 32'(irq_req), 32'd1);
    chk(irq_vec == 8'h77, "R9 vector held", 32'(irq_vec), 32'h77);
    drv_ack = 1'b1;
    @(negedge clk);
    drv_ack = 1'b0;
    chk(irq_req == 1'b0, "R9 cleared by ack", 32'(irq_req), 32'd0);
    auto_ack = 1'b1;

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R4 scoreboard drained", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    summary();
  end
endmodule